// File: doc/BRIEF.md
# Branch Monitoring Window and Trip Controller

This block is the global control that sits around a pair of branch-heuristic event counters. It owns the observation window: a counter advances on one selectable retirement stream (all instructions, branches, returns or indirect branches) and, once the programmed number of selected retirements has been seen, it sends a one-cycle reset strobe to both event counters. It also decides when heuristic counting is allowed. Counting is allowed only at user privilege, and, if software asks for it, not while the core runs as a virtualized guest.

The block merges the trip flags of the two counters. In "all" mode every enabled counter must be tripped. In "any" mode one enabled counter is enough. A counter whose enable is low never takes part in either mode. The first trip sets a sticky status bit and produces a single interrupt pulse. It can also produce a freeze pulse for the branch-record logic. Software clears the status bit, and that clear also restarts the window and resets the event counters. A configuration bit, presented on its own output, selects whether the interrupt is delivered as a normal or a non-maskable one.

Top module: `bmon_ctrl`

## Requirements
- R1: After reset the outputs `count_allow`, `ctr_reset`, `sts_flag`, `irq_pulse`, `irq_nmi` and `brec_freeze` are all 0. The configuration holds window size 1023, source 0, "any" combining, guest gating off, freeze off and normal interrupt. With these defaults the 1023rd counted instruction produces the strobe.
- R2: Only the stream selected by `cfg_src` advances the window. `ret_evt` bit k is stream k, with 0 = instructions, 1 = branches, 2 = returns and 3 = indirect branches. A configuration written with `cfg_we` is used from the next cycle on.
- R3: With window size N ≥ 1, `ctr_reset` is high for one cycle, one cycle after the cycle in which the Nth counted event arrives. The window then restarts from zero. With size 0, every counted event produces the strobe.
- R4: While `priv_lvl` is 0 (supervisor), no event advances the window, and `count_allow` is 0 one cycle later. While `priv_lvl` is nonzero and no other gate applies, `count_allow` is 1.
- R5: While the guest-disable bit is set and `guest_mode` is 1, counting is blocked in the same way as in R4. While the guest-disable bit is clear, `guest_mode` has no effect.
- R6: In "any" mode (`cfg_and_mode` = 0), a trip occurs when at least one counter has both its enable and its trip flag high.
- R7: In "all" mode (`cfg_and_mode` = 1), a trip occurs when at least one counter is enabled and every enabled counter is tripped. Trip flags of disabled counters are ignored.
- R8: One cycle after a trip, `sts_flag` rises and `irq_pulse` is high for exactly one cycle. While the status stays set, further trips give no further pulse.
- R9: `sts_clr` clears the status one cycle later, even when a trip is present in the same cycle. It also restarts the window and raises `ctr_reset` one cycle later.
- R10: When the freeze bit is set, `brec_freeze` pulses together with `irq_pulse`. When the freeze bit is clear, `brec_freeze` stays 0.
- R11: `irq_nmi` shows the non-maskable select bit, and it takes the written value one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads all configuration fields below |
| cfg_win_size | input | WIN_W (10) | Window length in selected retirements |
| cfg_src | input | SRC_W (2) | Window stream select |
| cfg_and_mode | input | 1 | 1 = all enabled counters must trip, 0 = any |
| cfg_guest_dis | input | 1 | Block counting in guest mode |
| cfg_freeze_en | input | 1 | Emit a branch-record freeze pulse on trip |
| cfg_nmi_sel | input | 1 | Interrupt class select |
| sts_clr | input | 1 | Software clear of the status bit |
| ret_evt | input | 2**SRC_W (4) | Per-stream retirement pulses |
| priv_lvl | input | 2 | Current privilege level, 0 = supervisor |
| guest_mode | input | 1 | Core runs as a virtualized guest |
| cnt_en | input | NUM_CNT (2) | Event counter enables |
| cnt_trip | input | NUM_CNT (2) | Event counter threshold flags |
| count_allow | output | 1 | Counting permitted (registered) |
| ctr_reset | output | 1 | Reset strobe to both event counters |
| sts_flag | output | 1 | Sticky detection status |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_nmi | output | 1 | 1 = deliver the interrupt as non-maskable |
| brec_freeze | output | 1 | One-cycle freeze to the branch-record logic |

## Verification
Every output is registered, so each result is due exactly one clock edge after the cycle in which its stimulus, configuration write or status clear is applied. This holds for the window strobe, the gating flag, the status, the interrupt and freeze pulses, and the interrupt class. For each cycle it drives, the driver pushes the expected output vector computed from the requirements. The monitor takes one entry per edge, one time unit after that edge, so every comparison lands in the cycle the result is due. Sequences cover the full default 1023-event window as well as sizes 0, 1 and small windows on each stream. They also cover supervisor and guest blocking, a trip that is held high, and a clear that coincides with a trip.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

  typedef enum logic {
    CMB_ANY = 1'b0,
    CMB_ALL = 1'b1
  } cmb_mode_e;

  typedef struct packed {
    cmb_mode_e cmb;
    logic      guest_dis;
    logic      freeze_en;
    logic      nmi_sel;
  } mode_bits_t;

  localparam mode_bits_t MODE_RESET = '{cmb: CMB_ANY, guest_dis: 1'b0,
                                        freeze_en: 1'b0, nmi_sel: 1'b0};

endpackage

// File: rtl/bmon_cfg.sv
module bmon_cfg
  import bmon_pkg::*;
#(
  parameter int WIN_W = 10,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIN_W-1:0] wr_size,
  input  logic [SRC_W-1:0] wr_src,
  input  logic             wr_and,
  input  logic             wr_gdis,
  input  logic             wr_frz,
  input  logic             wr_nmi,
  output logic [WIN_W-1:0] win_size,
  output logic [SRC_W-1:0] win_src,
  output mode_bits_t       mode
);

  localparam logic [WIN_W-1:0] SIZE_RESET = {WIN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_size <= SIZE_RESET;
      win_src  <= '0;
      mode     <= MODE_RESET;
    end else if (we) begin
      win_size       <= wr_size;
      win_src        <= wr_src;
      mode.cmb       <= wr_and ? CMB_ALL : CMB_ANY;
      mode.guest_dis <= wr_gdis;
      mode.freeze_en <= wr_frz;
      mode.nmi_sel   <= wr_nmi;
    end
  end

endmodule

// File: rtl/bmon_gate.sv
module bmon_gate #(
  parameter int SRC_W   = 2,
  parameter int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ret_evt,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [1:0]         priv_lvl,
  input  logic               guest_mode,
  input  logic               guest_dis,
  output logic               adv,
  output logic               allow_q
);

  logic allow;
  logic [NUM_SRC-1:0] evt_onehot;

  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_src
      assign evt_onehot[k] = ret_evt[k] && (src_sel == SRC_W'(k));
    end
  endgenerate

  assign allow = (priv_lvl != 2'd0) && !(guest_dis && guest_mode);
  assign adv   = allow && (|evt_onehot);

  always_ff @(posedge clk) begin
    if (rst) allow_q <= 1'b0;
    else     allow_q <= allow;
  end

  AST_SUPV_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == 2'd0) |=> !allow_q); // R4
  AST_GUEST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (guest_dis && guest_mode) |=> !allow_q); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_onehot)); // R2

endmodule

// File: rtl/bmon_window.sv
module bmon_window #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_size,
  input  logic             adv,
  input  logic             clr,
  output logic             strobe
);

  logic [WIN_W-1:0] cnt_q;
  logic             last;

  assign last = (win_size == '0) || (cnt_q >= (win_size - WIN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (clr) begin
        cnt_q  <= '0;
        strobe <= 1'b1;
      end else if (adv) begin
        if (last) begin
          cnt_q  <= '0;
          strobe <= 1'b1;
        end else begin
          cnt_q <= cnt_q + WIN_W'(1);
        end
      end
    end
  end

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q)); // R4
  AST_STRB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(adv || clr)); // R3
  AST_WIN_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/bmon_trip.sv
module bmon_trip
  import bmon_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] cnt_en,
  input  logic [NUM_CNT-1:0] cnt_trip,
  input  cmb_mode_e          cmb,
  input  logic               freeze_en,
  input  logic               clr,
  output logic               sts,
  output logic               irq,
  output logic               frz
);

  logic [NUM_CNT-1:0] hit_any;
  logic [NUM_CNT-1:0] ok_all;
  logic               trip_now;

  genvar i;
  generate
    for (i = 0; i < NUM_CNT; i++) begin : g_cnt
      assign hit_any[i] = cnt_en[i] & cnt_trip[i];
      assign ok_all[i]  = ~cnt_en[i] | cnt_trip[i];
    end
  endgenerate

  always_comb begin
    unique case (cmb)
      CMB_ALL: trip_now = (|cnt_en) && (&ok_all);
      default: trip_now = |hit_any;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 1'b0;
      irq <= 1'b0;
      frz <= 1'b0;
    end else begin
      irq <= 1'b0;
      frz <= 1'b0;
      if (clr) begin
        sts <= 1'b0;
      end else if (trip_now && !sts) begin
        sts <= 1'b1;
        irq <= 1'b1;
        frz <= freeze_en;
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R8
  AST_IRQ_WITH_STS: assert property (@(posedge clk) disable iff (rst)
    irq |-> sts); // R8
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts && !clr) |=> sts); // R8
  AST_STS_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sts); // R9
  AST_FRZ_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    frz |-> irq); // R10

endmodule

// File: rtl/bmon_ctrl.sv
module bmon_ctrl
  import bmon_pkg::*;
#(
  parameter int WIN_W   = 10,
  parameter int SRC_W   = 2,
  parameter int NUM_CNT = 2,
  localparam int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [WIN_W-1:0]   cfg_win_size,
  input  logic [SRC_W-1:0]   cfg_src,
  input  logic               cfg_and_mode,
  input  logic               cfg_guest_dis,
  input  logic               cfg_freeze_en,
  input  logic               cfg_nmi_sel,
  input  logic               sts_clr,
  input  logic [NUM_SRC-1:0] ret_evt,
  input  logic [1:0]         priv_lvl,
  input  logic               guest_mode,
  input  logic [NUM_CNT-1:0] cnt_en,
  input  logic [NUM_CNT-1:0] cnt_trip,
  output logic               count_allow,
  output logic               ctr_reset,
  output logic               sts_flag,
  output logic               irq_pulse,
  output logic               irq_nmi,
  output logic               brec_freeze
);

  logic [WIN_W-1:0] win_size;
  logic [SRC_W-1:0] win_src;
  mode_bits_t       mode;
  logic             adv;

  bmon_cfg #(.WIN_W(WIN_W), .SRC_W(SRC_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .wr_size(cfg_win_size), .wr_src(cfg_src), .wr_and(cfg_and_mode),
    .wr_gdis(cfg_guest_dis), .wr_frz(cfg_freeze_en), .wr_nmi(cfg_nmi_sel),
    .win_size(win_size), .win_src(win_src), .mode(mode)
  );

  bmon_gate #(.SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_gate (
    .clk(clk), .rst(rst), .ret_evt(ret_evt), .src_sel(win_src),
    .priv_lvl(priv_lvl), .guest_mode(guest_mode), .guest_dis(mode.guest_dis),
    .adv(adv), .allow_q(count_allow)
  );

  bmon_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .win_size(win_size), .adv(adv),
    .clr(sts_clr), .strobe(ctr_reset)
  );

  bmon_trip #(.NUM_CNT(NUM_CNT)) u_trip (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_trip(cnt_trip),
    .cmb(mode.cmb), .freeze_en(mode.freeze_en), .clr(sts_clr),
    .sts(sts_flag), .irq(irq_pulse), .frz(brec_freeze)
  );

  assign irq_nmi = mode.nmi_sel;

  AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (irq_nmi == $past(cfg_nmi_sel))); // R11
  AST_CLR_STROBE: assert property (@(posedge clk) disable iff (rst)
    sts_clr |=> ctr_reset); // R9

endmodule

// File: tb/tb_bmon_ctrl.sv
module tb_bmon_ctrl;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_win_size = '0;
  logic [1:0] cfg_src = '0;
  logic       cfg_and_mode = 1'b0, cfg_guest_dis = 1'b0;
  logic       cfg_freeze_en = 1'b0, cfg_nmi_sel = 1'b0;
  logic       sts_clr = 1'b0;
  logic [3:0] ret_evt = '0;
  logic [1:0] priv_lvl = '0;
  logic       guest_mode = 1'b0;
  logic [1:0] cnt_en = '0, cnt_trip = '0;
  logic       count_allow, ctr_reset, sts_flag, irq_pulse, irq_nmi, brec_freeze;

  bmon_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [5:0] expq[$];
  string      tagq[$];
  logic [5:0] act, expv;
  string      tg;

  // reference state, derived from the requirements
  int   m_size = 1023, m_src = 0, m_cnt = 0;
  bit   m_and = 0, m_gdis = 0, m_frz = 0, m_nmi = 0, m_sts = 0;

  task automatic model_push(input string tag);
    bit allow, adv, e_ctr, trip, e_irq, e_frz;
    int n_en, n_tr;
    allow = (priv_lvl != 0) && !(m_gdis && guest_mode);
    adv   = ret_evt[m_src] && allow;
    e_ctr = 0; e_irq = 0; e_frz = 0;
    if (sts_clr) begin m_cnt = 0; e_ctr = 1; end
    else if (adv) begin
      if (m_size == 0 || m_cnt + 1 >= m_size) begin m_cnt = 0; e_ctr = 1; end
      else m_cnt++;
    end
    n_en = 0; n_tr = 0;
    for (int i = 0; i < 2; i++) begin
      if (cnt_en[i]) begin n_en++; if (cnt_trip[i]) n_tr++; end
    end
    trip = m_and ? (n_en > 0 && n_tr == n_en) : (n_tr > 0);
    if (sts_clr) m_sts = 0;
    else if (trip && !m_sts) begin m_sts = 1; e_irq = 1; e_frz = m_frz; end
    if (cfg_we) begin
      m_size = cfg_win_size; m_src = cfg_src; m_and = cfg_and_mode;
      m_gdis = cfg_guest_dis; m_frz = cfg_freeze_en; m_nmi = cfg_nmi_sel;
    end
    expq.push_back({allow, e_ctr, m_sts, e_irq, e_frz, m_nmi});
    tagq.push_back(tag);
  endtask

  task automatic tick(input logic [3:0] evt, input logic [1:0] pv, input logic gst,
                      input logic [1:0] en, input logic [1:0] tr, input logic clr,
                      input string tag);
    @(negedge clk);
    cfg_we = 0; ret_evt = evt; priv_lvl = pv; guest_mode = gst;
    cnt_en = en; cnt_trip = tr; sts_clr = clr;
    model_push(tag);
  endtask

  task automatic cfgw(input int size, input int src, input bit am, input bit gd,
                      input bit fz, input bit nm, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_win_size = 10'(size); cfg_src = 2'(src);
    cfg_and_mode = am; cfg_guest_dis = gd; cfg_freeze_en = fz; cfg_nmi_sel = nm;
    ret_evt = '0; priv_lvl = 2'd3; guest_mode = 0; cnt_en = '0; cnt_trip = '0;
    sts_clr = 0;
    model_push(tag);
  endtask

  // monitor: one expected vector per edge, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      expv = expq.pop_front();
      tg   = tagq.pop_front();
      act  = {count_allow, ctr_reset, sts_flag, irq_pulse, brec_freeze, irq_nmi};
      checks++;
      if (act !== expv) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b (allow,rst,sts,irq,frz,nmi)",
                 tg, act, expv);
      end
    end
  end

  task automatic trip_case(input logic [1:0] en, input logic [1:0] tr, input string tag);
    tick(4'h0, 2'd3, 0, en, tr, 0, tag);
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 0, tag);
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 1, tag);
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({count_allow, ctr_reset, sts_flag, irq_pulse, brec_freeze, irq_nmi} !== 6'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%b expected=000000",
               {count_allow, ctr_reset, sts_flag, irq_pulse, brec_freeze, irq_nmi});
    end
    @(negedge clk); rst = 0;

    // R1: default window of 1023 instructions
    for (int n = 0; n < 1030; n++) tick(4'h1, 2'd3, 0, 2'b00, 2'b00, 0, "R1");

    // R2: branch stream, window 4; other streams must not count
    cfgw(4, 1, 0, 0, 0, 0, "R2");
    for (int n = 0; n < 24; n++)
      tick((n % 3 == 0) ? 4'b0010 : 4'b1101, 2'd1, 0, 2'b00, 2'b00, 0, "R2");
    cfgw(3, 2, 0, 0, 0, 0, "R2");
    for (int n = 0; n < 16; n++)
      tick((n % 2 == 0) ? 4'b0100 : 4'b1011, 2'd2, 0, 2'b00, 2'b00, 0, "R2");
    cfgw(2, 3, 0, 0, 0, 0, "R2");
    for (int n = 0; n < 12; n++)
      tick(4'(n), 2'd3, 0, 2'b00, 2'b00, 0, "R2");

    // R3: size 0 and size 1 strobe on every counted event
    cfgw(0, 0, 0, 0, 0, 0, "R3");
    for (int n = 0; n < 10; n++) tick((n % 2 == 0) ? 4'h1 : 4'h0, 2'd3, 0, 2'b00, 2'b00, 0, "R3");
    cfgw(1, 0, 0, 0, 0, 0, "R3");
    for (int n = 0; n < 6; n++) tick(4'h1, 2'd3, 0, 2'b00, 2'b00, 0, "R3");

    // R4: supervisor blocks, window resumes where it stopped
    cfgw(5, 0, 0, 0, 0, 0, "R4");
    for (int n = 0; n < 3; n++) tick(4'h1, 2'd3, 0, 2'b00, 2'b00, 0, "R4");
    for (int n = 0; n < 8; n++) tick(4'h1, 2'd0, 0, 2'b00, 2'b00, 0, "R4");
    for (int n = 0; n < 6; n++) tick(4'h1, 2'd2, 0, 2'b00, 2'b00, 0, "R4");

    // R5: guest mode gating only when enabled
    for (int n = 0; n < 6; n++) tick(4'h1, 2'd3, 1, 2'b00, 2'b00, 0, "R5");
    cfgw(5, 0, 0, 1, 0, 0, "R5");
    for (int n = 0; n < 8; n++) tick(4'h1, 2'd3, 1, 2'b00, 2'b00, 0, "R5");
    for (int n = 0; n < 6; n++) tick(4'h1, 2'd3, 0, 2'b00, 2'b00, 0, "R5");

    // R6: any-mode combining
    cfgw(1023, 0, 0, 0, 0, 0, "R6");
    trip_case(2'b01, 2'b01, "R6");
    trip_case(2'b10, 2'b01, "R6");
    trip_case(2'b11, 2'b10, "R6");
    trip_case(2'b00, 2'b11, "R6");

    // R7: all-mode combining, disabled counters ignored
    cfgw(1023, 0, 1, 0, 0, 0, "R7");
    trip_case(2'b11, 2'b01, "R7");
    trip_case(2'b11, 2'b11, "R7");
    trip_case(2'b01, 2'b01, "R7");
    trip_case(2'b10, 2'b01, "R7");
    trip_case(2'b00, 2'b11, "R7");

    // R8: held trip gives one pulse, sticky status
    for (int n = 0; n < 6; n++) tick(4'h0, 2'd3, 0, 2'b11, 2'b11, 0, "R8");
    // R9: clear coinciding with a held trip, then re-trip
    tick(4'h0, 2'd3, 0, 2'b11, 2'b11, 1, "R9");
    for (int n = 0; n < 3; n++) tick(4'h0, 2'd3, 0, 2'b11, 2'b11, 0, "R9");
    tick(4'h1, 2'd3, 0, 2'b00, 2'b00, 1, "R9");
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 0, "R9");

    // R10: freeze pulse follows the interrupt
    cfgw(1023, 0, 0, 0, 1, 0, "R10");
    trip_case(2'b01, 2'b01, "R10");
    for (int n = 0; n < 4; n++) tick(4'h0, 2'd3, 0, 2'b01, 2'b01, 0, "R10");

    // R11: interrupt class select
    cfgw(1023, 0, 0, 0, 0, 1, "R11");
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 0, "R11");
    cfgw(1023, 0, 0, 0, 0, 0, "R11");
    tick(4'h0, 2'd3, 0, 2'b00, 2'b00, 0, "R11");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule